// File: doc/BRIEF.md
# I2C SCL Clock Timing Generator

This block produces the SCL waveform for an I2C master from the system clock, together with strobes that tell the master's byte engine where the SCL edges and the SDA change point fall. A configuration word sets three values: a power-of-two exponent for a base prescaler, a high-phase count and a low-phase count. Each count is stored as the phase length minus one, and both are measured in base ticks. So one SCL period lasts `(1 << base) * ((high + 1) + (low + 1))` system clocks.

The block drives SCL low for the low phase and releases it for the high phase. While SCL is released, it watches the synchronized bus line. If a slave holds the line low (clock stretching), the high-phase count holds until the line is seen high. A new configuration word takes effect only at the start of a low phase, so a period in progress is never corrupted. When `enable` is low the block is idle: SCL is released, no strobes fire, and it starts again with a low phase.

Top module: `scl_timing_gen`

## Requirements
- R1: With no clock stretching, the distance between consecutive `fallStrobe` pulses is `(1 << base) * (high + low + 2)` clock cycles.
- R2: `sclDrive` is 0 for `(1 << base) * (low + 1)` cycles and then 1 for `(1 << base) * (high + 1)` cycles.
- R3: A field value of 0 gives a phase one base tick long; with base = high = low = 0 the period is 2 cycles.
- R4: While the block is active, `baseTick` is a single-cycle pulse once every `1 << base` cycles, from a prescaler that restarts at every configuration load; it is 0 when idle.
- R5: `riseStrobe` is high in the last cycle of a low phase and `fallStrobe` in the last cycle of a high phase; `sclDrive` changes in the following cycle.
- R6: `midLowStrobe` fires exactly once per low phase, on the base tick at which the low count equals `low >> 1`, and never while `sclDrive` is 1.
- R7: When the line reads low while SCL is released, the high count holds; the stall is seen two cycles late, so a slave holding SCL low for K cycles at base 0 lengthens the period by K cycles.
- R8: A configuration change takes effect only at the next fall of SCL; the period that is running completes with the old values.
- R9: When `enable` is 0, or during reset, `sclDrive` is 1 and all strobes and `baseTick` are 0; once `enable` rises, the next cycle starts a low phase.
- R10: Field positions in `cfgWord`: high count in bits 19:16, low count in bits 15:12, base exponent in bits 3:0; all other bits are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Run the SCL generator |
| cfgWord | input | 32 | Timing word (high, low, base fields) |
| sclIn | input | 1 | Raw SCL bus line, synchronized inside |
| sclDrive | output | 1 | 0 = pull SCL low, 1 = release |
| baseTick | output | 1 | Prescaler tick pulse |
| riseStrobe | output | 1 | Last cycle of the low phase |
| fallStrobe | output | 1 | Last cycle of the high phase |
| midLowStrobe | output | 1 | SDA may change here |

## Verification
The strobes and `baseTick` are combinational from registered state, so they are due in the same cycle as the prescaler tick that causes them. `sclDrive` follows one cycle after a strobe. A line held low appears in the stall decision two cycles later, because it passes through the synchronizer. The bench drives its inputs at the falling edge and samples one time unit later. Its reference model advances once per cycle and carries the same two-cycle line delay, so every compare falls in the cycle the requirement names. The interval checks count cycles between strobes, and they skip the first interval after a configuration change except where R8 calls for it.

// File: rtl/scl_timing_pkg.sv
package scl_timing_pkg;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_LOW  = 2'd1,
    PH_HIGH = 2'd2
  } phase_e;

  // Control to datapath
  typedef struct packed {
    logic run;
    logic prescClr;
    logic cntClr;
    logic cntInc;
    logic loadCfg;
    logic selHigh;
  } dp_ctl_t;

  // Datapath to control
  typedef struct packed {
    logic tick;
    logic atEnd;
    logic atMid;
    logic stall;
  } dp_sts_t;

endpackage

// File: rtl/scl_timing_dp.sv
module scl_timing_dp
  import scl_timing_pkg::*;
#(
  parameter int CFG_W       = 32,
  parameter int FIELD_W     = 4,
  parameter int BASE_W      = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [CFG_W-1:0] cfgWord,
  input  logic             sclIn,
  input  logic             sclDrive,
  input  dp_ctl_t          ctl,
  output dp_sts_t          sts
);
  localparam int HI_LSB  = 16;
  localparam int LO_LSB  = 12;
  localparam int PRESC_W = 1 << BASE_W;

  logic [BASE_W-1:0]  baseR;
  logic [FIELD_W-1:0] highR, lowR, phaseCnt;
  logic [PRESC_W-1:0] presc, prescLim;
  logic [SYNC_STAGES-1:0] lineQ, driveQ;
  logic tick;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      baseR <= '0;
      highR <= '0;
      lowR  <= '0;
    end else if (ctl.loadCfg) begin
      baseR <= cfgWord[BASE_W-1:0];
      highR <= cfgWord[HI_LSB +: FIELD_W];
      lowR  <= cfgWord[LO_LSB +: FIELD_W];
    end
  end

  assign prescLim = (PRESC_W'(1) << baseR) - PRESC_W'(1);
  assign tick     = ctl.run && (presc == prescLim);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                   presc <= '0;
    else if (ctl.prescClr || tick) presc <= '0;
    else                         presc <= presc + PRESC_W'(1);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           phaseCnt <= '0;
    else if (ctl.cntClr) phaseCnt <= '0;
    else if (ctl.cntInc) phaseCnt <= phaseCnt + FIELD_W'(1);
  end

  // Line synchronizer and matching delay of what was driven
  generate
    for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          lineQ[s]  <= 1'b1;
          driveQ[s] <= 1'b1;
        end else begin
          lineQ[s]  <= (s == 0) ? sclIn    : lineQ[(s == 0) ? 0 : s-1];
          driveQ[s] <= (s == 0) ? sclDrive : driveQ[(s == 0) ? 0 : s-1];
        end
      end
    end
  endgenerate

  assign sts.tick  = tick;
  assign sts.atEnd = phaseCnt == (ctl.selHigh ? highR : lowR);
  assign sts.atMid = phaseCnt == (lowR >> 1);
  assign sts.stall = driveQ[SYNC_STAGES-1] && !lineQ[SYNC_STAGES-1];

  p_tick_single_r4: assert property (@(posedge clk) disable iff (!rstN)
    (tick && baseR != '0 && !ctl.loadCfg) |=> !tick);

  p_stretch_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.selHigh && sts.stall && !ctl.cntClr) |=> $stable(phaseCnt));

endmodule

// File: rtl/scl_timing_ctl.sv
module scl_timing_ctl
  import scl_timing_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    enable,
  input  dp_sts_t sts,
  output dp_ctl_t ctl,
  output logic    sclDrive,
  output logic    riseStrobe,
  output logic    fallStrobe,
  output logic    midLowStrobe
);
  phase_e ph, phNext;
  logic advHigh;

  assign advHigh = (ph == PH_HIGH) && sts.tick && !sts.stall;

  always_comb begin
    ctl          = '0;
    phNext       = ph;
    ctl.run      = (ph != PH_IDLE);
    ctl.selHigh  = (ph == PH_HIGH);
    case (ph)
      PH_IDLE: begin
        ctl.prescClr = 1'b1;
        ctl.cntClr   = 1'b1;
        phNext       = PH_LOW;
        ctl.loadCfg  = 1'b1;
      end
      PH_LOW: begin
        if (sts.tick) begin
          if (sts.atEnd) begin
            phNext     = PH_HIGH;
            ctl.cntClr = 1'b1;
          end else begin
            ctl.cntInc = 1'b1;
          end
        end
      end
      PH_HIGH: begin
        if (advHigh) begin
          if (sts.atEnd) begin
            phNext      = PH_LOW;
            ctl.cntClr  = 1'b1;
            ctl.loadCfg = 1'b1;
          end else begin
            ctl.cntInc = 1'b1;
          end
        end
      end
      default: phNext = PH_IDLE;
    endcase
    if (!enable) begin
      phNext       = PH_IDLE;
      ctl.prescClr = 1'b1;
      ctl.cntClr   = 1'b1;
      ctl.cntInc   = 1'b0;
      ctl.loadCfg  = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) ph <= PH_IDLE;
    else       ph <= phNext;
  end

  assign sclDrive     = (ph != PH_LOW);
  assign riseStrobe   = (ph == PH_LOW) && sts.tick && sts.atEnd;
  assign midLowStrobe = (ph == PH_LOW) && sts.tick && sts.atMid;
  assign fallStrobe   = advHigh && sts.atEnd;

  p_rise_release_r5: assert property (@(posedge clk) disable iff (!rstN)
    (riseStrobe && enable) |=> sclDrive);

  p_fall_pull_r5: assert property (@(posedge clk) disable iff (!rstN)
    (fallStrobe && enable) |=> !sclDrive);

  p_mid_in_low_r6: assert property (@(posedge clk) disable iff (!rstN)
    midLowStrobe |-> !sclDrive);

  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rstN)
    !$past(enable) |-> (sclDrive && !riseStrobe && !fallStrobe && !midLowStrobe));

endmodule

// File: rtl/scl_timing_gen.sv
module scl_timing_gen
  import scl_timing_pkg::*;
#(
  parameter int CFG_W       = 32,
  parameter int FIELD_W     = 4,
  parameter int BASE_W      = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             enable,
  input  logic [CFG_W-1:0] cfgWord,
  input  logic             sclIn,
  output logic             sclDrive,
  output logic             baseTick,
  output logic             riseStrobe,
  output logic             fallStrobe,
  output logic             midLowStrobe
);
  dp_ctl_t ctl;
  dp_sts_t sts;

  scl_timing_dp #(
    .CFG_W(CFG_W), .FIELD_W(FIELD_W), .BASE_W(BASE_W), .SYNC_STAGES(SYNC_STAGES)
  ) i_dp (
    .clk(clk), .rstN(rstN), .cfgWord(cfgWord), .sclIn(sclIn),
    .sclDrive(sclDrive), .ctl(ctl), .sts(sts)
  );

  scl_timing_ctl i_ctl (
    .clk(clk), .rstN(rstN), .enable(enable), .sts(sts), .ctl(ctl),
    .sclDrive(sclDrive), .riseStrobe(riseStrobe), .fallStrobe(fallStrobe),
    .midLowStrobe(midLowStrobe)
  );

  assign baseTick = sts.tick;

endmodule

// File: tb/test_scl_timing_gen.sv
`timescale 1ns/1ps
module test_scl_timing_gen;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic enable = 1'b0;
  logic [31:0] cfgWord = '0;
  logic stretchNow = 1'b0;
  logic sclIn;
  logic sclDrive, baseTick, riseStrobe, fallStrobe, midLowStrobe;

  always #4 clk = ~clk;
  assign sclIn = sclDrive & ~stretchNow;

  scl_timing_gen i_scl_timing_gen (
    .clk(clk), .rstN(rstN), .enable(enable), .cfgWord(cfgWord), .sclIn(sclIn),
    .sclDrive(sclDrive), .baseTick(baseTick), .riseStrobe(riseStrobe),
    .fallStrobe(fallStrobe), .midLowStrobe(midLowStrobe)
  );

  int checks = 0, errors = 0, cyc = 0;
  // reference model state
  int mS = 0, mP = 0, mC = 0, mB = 0, mH = 0, mL = 0;
  int mL1 = 1, mL2 = 1, mD1 = 1, mD2 = 1;
  int hiAge = 0, stretchK = 0;
  int prevFall = -1, prevRise = -1, nF = 0, midCnt = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s at cycle %0d: actual %0d expected %0d", tag, cyc, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(input int b, input int h, input int l);
    return {12'h000, h[3:0], l[3:0], 8'h00, b[3:0]};
  endfunction

  // one cycle: called at a falling edge
  task automatic step(input int expPer, input int expLow, input int expHigh, input int firstPer);
    int eTick, eStall, eRise, eMid, eAdv, eFall, eDrive, line;
    stretchNow = (stretchK > 0) && sclDrive && (hiAge < stretchK);
    #1;
    eTick  = (mS != 0) && (mP == (1 << mB) - 1);
    eStall = mD2 && !mL2;
    eRise  = (mS == 1) && eTick && (mC == mL);
    eMid   = (mS == 1) && eTick && (mC == (mL >> 1));
    eAdv   = (mS == 2) && eTick && !eStall;
    eFall  = eAdv && (mC == mH);
    eDrive = (mS != 1);
    chk(sclDrive == eDrive, "R2 sclDrive", sclDrive, eDrive);
    chk(baseTick == eTick, "R4 baseTick", baseTick, eTick);
    chk(riseStrobe == eRise, "R5 riseStrobe", riseStrobe, eRise);
    chk(fallStrobe == eFall, "R5 fallStrobe", fallStrobe, eFall);
    chk(midLowStrobe == eMid, "R6 midLowStrobe", midLowStrobe, eMid);
    // interval checks from the ports
    if (midLowStrobe) midCnt++;
    if (riseStrobe) begin
      if (nF >= 1 && expLow > 0) chk(cyc - prevFall == expLow, "R2 low length", cyc - prevFall, expLow);
      prevRise = cyc;
    end
    if (fallStrobe) begin
      if (nF >= 1 && expPer > 0) begin
        chk(cyc - prevFall == expPer, "R1 period", cyc - prevFall, expPer);
        chk(cyc - prevRise == expHigh, "R2/R7 high length", cyc - prevRise, expHigh);
        chk(midCnt == 1, "R6 mid per low phase", midCnt, 1);
      end else if (nF == 0 && firstPer > 0 && prevFall >= 0) begin
        chk(cyc - prevFall == firstPer, "R8 old period kept", cyc - prevFall, firstPer);
      end
      prevFall = cyc; nF++; midCnt = 0;
    end
    hiAge = sclDrive ? hiAge + 1 : 0;
    // model update
    line = eDrive && !stretchNow;
    if (!rstN) begin
      mS = 0; mP = 0; mC = 0; mB = 0; mH = 0; mL = 0;
      mL1 = 1; mL2 = 1; mD1 = 1; mD2 = 1;
    end else begin
      mL2 = mL1; mL1 = line; mD2 = mD1; mD1 = eDrive;
      if (!enable) begin
        mS = 0; mP = 0; mC = 0;
      end else if (mS == 0) begin
        mS = 1; mP = 0; mC = 0;
        mB = cfgWord[3:0]; mH = cfgWord[19:16]; mL = cfgWord[15:12];
      end else begin
        mP = eTick ? 0 : mP + 1;
        if (mS == 1 && eTick) begin
          if (eRise) begin mS = 2; mC = 0; end else mC++;
        end
        if (eAdv) begin
          if (eFall) begin
            mS = 1; mC = 0;
            mB = cfgWord[3:0]; mH = cfgWord[19:16]; mL = cfgWord[15:12];
          end else mC++;
        end
      end
    end
    cyc++;
    @(negedge clk);
  endtask

  task automatic runPhase(input logic [31:0] cfg, input int k, input int n,
                          input int expPer, input int expLow, input int expHigh, input int firstPer);
    cfgWord = cfg; stretchK = k; nF = 0;
    for (int i = 0; i < n; i++) step(expPer, expLow, expHigh, firstPer);
  endtask

  initial begin
    #1600000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int strobes;
    @(negedge clk);
    // R9: reset state
    for (int i = 0; i < 4; i++) begin
      chk(sclDrive == 1'b1, "R9 reset sclDrive", sclDrive, 1);
      chk({riseStrobe, fallStrobe, midLowStrobe, baseTick} == 4'b0, "R9 reset strobes",
          {riseStrobe, fallStrobe, midLowStrobe, baseTick}, 0);
      step(0, 0, 0, 0);
    end
    rstN = 1'b1; enable = 1'b1;
    // R3: minimum phases
    runPhase(mk(0, 0, 0), 0, 40, 2, 1, 1, 0);
    // R1: base 1, high 2, low 1 -> 2*(3+2) = 10
    runPhase(mk(1, 2, 1), 0, 100, 10, 4, 6, 2);
    // R10: junk in unused bits; base 2, high 15, low 7 -> 4*24 = 96
    runPhase(32'hABCF_7FF2, 0, 300, 96, 32, 64, 10);
    // R8: switch mid-period, running period completes with old values
    runPhase(mk(1, 2, 1), 0, 100, 10, 4, 6, 96);
    // R7: stretch 4 cycles at base 0, high 5, low 3 -> 10 + 4
    runPhase(mk(0, 5, 3), 4, 150, 14, 4, 10, 0);
    // R9: disabled, no strobes and SCL released
    enable = 1'b0; stretchK = 0; strobes = 0;
    for (int i = 0; i < 30; i++) begin
      if (i > 0) begin
        strobes += riseStrobe + fallStrobe + midLowStrobe + baseTick;
        chk(sclDrive == 1'b1, "R9 idle sclDrive", sclDrive, 1);
      end
      step(0, 0, 0, 0);
    end
    chk(strobes == 0, "R9 idle strobe count", strobes, 0);
    enable = 1'b1; prevFall = -1;
    step(0, 0, 0, 0);
    chk(sclDrive == 1'b0, "R9 restart with low phase", sclDrive, 0);
    runPhase(mk(0, 0, 0), 0, 20, 2, 1, 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule